// File: doc/BRIEF.md
# Phase-Corrected Return Path Rotator

This block sits in the digital part of a Cartesian feedback transmitter loop. Each sample carries three things: a feedback I/Q pair from the demodulator's converters, a forward-path I/Q pair, and a phase-correction angle. The block turns the feedback vector through the correction angle with a shift-and-add CORDIC in rotation mode. It scales the result by a fixed constant that cancels the CORDIC gain. It then subtracts the scaled vector from the forward-path sample and sends the return I/Q pair to the DACs.

The nine micro-rotations are grouped three to a pipeline register. A quadrant pre-rotation stage comes first and a subtract-and-clip stage comes last. A delay line carries the forward-path sample alongside the rotator, so the subtraction always pairs operands from the same input cycle. The total latency is five register stages, which is far below one chip period at the loop's sample rates.

Top module: `cfb_return_path`

## Requirements
- R1: A sample is accepted only on a rising edge where `fb_valid`, `in_valid` and `ang_valid` are all high. In any other cycle all data inputs are ignored and no result is produced.
- R2: `out_valid` rises on the fourth rising edge after the edge that accepted the sample (five register stages in all). It stays high for exactly one cycle per accepted sample.
- R3: The result is `in - R(theta)*fb`, where R(theta) maps (I, Q) to (cos*I - sin*Q, sin*I + cos*Q). Each component is within 10 LSB of the exact value when both feedback components lie in [-1024, 1024].
- R4: The angle is a signed AW-bit two's-complement number. The value 2^(AW-1) stands for pi radians, and positive values turn the vector counterclockwise.
- R5: Any angle in the full range, including -pi and values beyond +/-pi/2, meets the R3 accuracy. A pre-rotation by +/-90 degrees brings the residual angle within +/-pi/2 before the nine iterations.
- R6: The CORDIC gain is compensated. With a zero angle, the result equals `in - fb` within the R3 tolerance.
- R7: Each output component saturates to [-2^(DW-1), 2^(DW-1)-1] instead of wrapping.
- R8: A synchronous active-high reset clears `out_valid`, `out_i` and `out_q` to zero.
- R9: Samples may arrive on every cycle. Each result belongs to the forward-path and feedback operands that were accepted on the same edge.
- R10: While `out_valid` is low, `out_i` and `out_q` keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_valid | input | 1 | Feedback sample strobe |
| fb_i | input | DW | Feedback in-phase sample, signed |
| fb_q | input | DW | Feedback quadrature sample, signed |
| in_valid | input | 1 | Forward-path sample strobe |
| in_i | input | DW | Forward-path in-phase sample, signed |
| in_q | input | DW | Forward-path quadrature sample, signed |
| ang_valid | input | 1 | Correction angle strobe |
| ang | input | AW | Correction angle, signed, 2^(AW-1) = pi |
| out_valid | output | 1 | Return sample strobe |
| out_i | output | DW | Return in-phase sample, signed |
| out_q | output | DW | Return quadrature sample, signed |

## Verification
The bench drives angles beyond the +/-90 degree range, including exactly -pi and +pi/2. A design without the quadrant pre-rotation would leave a large residual angle there and miss the exact result by hundreds of LSB. Zero-angle samples expose a missing or wrong gain constant, which would scale the feedback by about 1.65. Back-to-back bursts catch a delay line one stage off, because the subtraction would then mix neighbouring samples. Samples with only two of the three strobes, plus idle cycles filled with junk data, catch a result that fires wrongly or outputs that drift while idle. Large opposite-signed operands show whether the subtraction wraps instead of clipping.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  // Arctangent of 2^-i, scaled so that 2^15 units equal pi.
  function automatic int atan_ref(input int i);
    case (i)
      0: return 8192;
      1: return 4836;
      2: return 2555;
      3: return 1297;
      4: return 651;
      5: return 326;
      6: return 163;
      7: return 81;
      8: return 41;
      default: return 10430 >> i;
    endcase
  endfunction

  // Same table, rescaled to an angle word of aw bits.
  function automatic int atan_scaled(input int i, input int aw);
    int v;
    v = atan_ref(i);
    if (aw >= 16) return v <<< (aw - 16);
    return v >>> (16 - aw);
  endfunction

endpackage

// File: rtl/cfb_prerot.sv
module cfb_prerot #(
  parameter int DW    = 12,
  parameter int AW    = 16,
  parameter int GUARD = 4,
  parameter int IW    = DW + GUARD + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [DW-1:0] fb_i,
  input  logic signed [DW-1:0] fb_q,
  input  logic signed [AW-1:0] ang,
  output logic                 v_out,
  output logic signed [IW-1:0] x_out,
  output logic signed [IW-1:0] y_out,
  output logic signed [AW-1:0] z_out
);
  localparam logic signed [AW-1:0] QTR = AW'(1 << (AW - 2));

  logic signed [IW-1:0] xe, ye, xn, yn;
  logic signed [AW-1:0] zn;

  assign xe = IW'(fb_i) <<< GUARD;
  assign ye = IW'(fb_q) <<< GUARD;

  // Fold the angle into +/-pi/2 with an exact quarter turn.
  always_comb begin
    xn = xe;
    yn = ye;
    zn = ang;
    case (ang[AW-1:AW-2])
      2'b01: begin xn = -ye; yn = xe;  zn = ang - QTR; end
      2'b10: begin xn = ye;  yn = -xe; zn = ang + QTR; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else begin
      v_out <= v_in;
      x_out <= xn;
      y_out <= yn;
      z_out <= zn;
    end
  end

  AST_PREROT_RANGE: assert property (@(posedge clk) disable iff (rst)
    v_out |-> (z_out >= -QTR && z_out <= QTR)); // R5

endmodule

// File: rtl/cfb_cordic_group.sv
module cfb_cordic_group
  import cfb_pkg::*;
#(
  parameter int IW    = 18,
  parameter int AW    = 16,
  parameter int FIRST = 0,
  parameter int CNT   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [IW-1:0] x_in,
  input  logic signed [IW-1:0] y_in,
  input  logic signed [AW-1:0] z_in,
  output logic                 v_out,
  output logic signed [IW-1:0] x_out,
  output logic signed [IW-1:0] y_out,
  output logic signed [AW-1:0] z_out
);
  logic signed [IW-1:0] xs [0:CNT];
  logic signed [IW-1:0] ys [0:CNT];
  logic signed [AW-1:0] zs [0:CNT];

  // CNT chained micro-rotations, no register in between.
  always_comb begin
    xs[0] = x_in;
    ys[0] = y_in;
    zs[0] = z_in;
    for (int k = 0; k < CNT; k++) begin
      if (zs[k][AW-1]) begin
        xs[k+1] = xs[k] + (ys[k] >>> (FIRST + k));
        ys[k+1] = ys[k] - (xs[k] >>> (FIRST + k));
        zs[k+1] = zs[k] + AW'(atan_scaled(FIRST + k, AW));
      end else begin
        xs[k+1] = xs[k] - (ys[k] >>> (FIRST + k));
        ys[k+1] = ys[k] + (xs[k] >>> (FIRST + k));
        zs[k+1] = zs[k] - AW'(atan_scaled(FIRST + k, AW));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else begin
      v_out <= v_in;
      x_out <= xs[CNT];
      y_out <= ys[CNT];
      z_out <= zs[CNT];
    end
  end

endmodule

// File: rtl/cfb_align.sv
module cfb_align #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < DEPTH; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[DEPTH-1];

endmodule

// File: rtl/cfb_sub_sat.sv
module cfb_sub_sat #(
  parameter int DW    = 12,
  parameter int GUARD = 4,
  parameter int IW    = DW + GUARD + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [IW-1:0] rx,
  input  logic signed [IW-1:0] ry,
  input  logic signed [DW-1:0] ii,
  input  logic signed [DW-1:0] iq,
  output logic                 v_out,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int SW = DW + 3;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = SW'(-(1 << (DW - 1)));
  localparam logic signed [IW-1:0] RND  = IW'(1 << (GUARD - 1));

  // 1/2 + 1/8 - 1/64 - 1/512 - 1/4096 = 0.60718
  function automatic logic signed [IW-1:0] gain(input logic signed [IW-1:0] a);
    return (a >>> 1) + (a >>> 3) - (a >>> 6) - (a >>> 9) - (a >>> 12);
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] d);
    if (d > MAXV) return DW'(MAXV);
    if (d < MINV) return DW'(MINV);
    return DW'(d);
  endfunction

  logic signed [IW-1:0] ti, tq;
  logic signed [SW-1:0] rot_i, rot_q, di, dq;

  always_comb begin
    ti    = (gain(rx) + RND) >>> GUARD;
    tq    = (gain(ry) + RND) >>> GUARD;
    rot_i = SW'(ti);
    rot_q = SW'(tq);
    di    = SW'(ii) + ~rot_i + SW'(1);
    dq    = SW'(iq) + ~rot_q + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      out_i <= '0;
      out_q <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        out_i <= clip(di);
        out_q <= clip(dq);
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> ($stable(out_i) && $stable(out_q))); // R10
  AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (v_in && di > MAXV) |=> (out_i == DW'(MAXV))); // R7
  AST_CLIP_LOW: assert property (@(posedge clk) disable iff (rst)
    (v_in && dq < MINV) |=> (out_q == DW'(MINV))); // R7

endmodule

// File: rtl/cfb_return_path.sv
module cfb_return_path
  import cfb_pkg::*;
#(
  parameter int DW    = 12,
  parameter int AW    = 16,
  parameter int ITER  = 9,
  parameter int GRP   = 3,
  parameter int GUARD = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fb_valid,
  input  logic signed [DW-1:0] fb_i,
  input  logic signed [DW-1:0] fb_q,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 ang_valid,
  input  logic signed [AW-1:0] ang,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int IW   = DW + GUARD + 2;
  localparam int NGRP = (ITER + GRP - 1) / GRP;
  localparam int ALN  = NGRP + 1;

  logic                 fire;
  logic                 gv [0:NGRP];
  logic signed [IW-1:0] gx [0:NGRP];
  logic signed [IW-1:0] gy [0:NGRP];
  logic signed [AW-1:0] gz [0:NGRP];
  logic [2*DW-1:0]      fwd_d;

  assign fire = fb_valid & in_valid & ang_valid;

  cfb_prerot #(.DW(DW), .AW(AW), .GUARD(GUARD), .IW(IW)) u_prerot (
    .clk(clk), .rst(rst), .v_in(fire), .fb_i(fb_i), .fb_q(fb_q), .ang(ang),
    .v_out(gv[0]), .x_out(gx[0]), .y_out(gy[0]), .z_out(gz[0])
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_stage
    localparam int FIRST = g * GRP;
    localparam int CNT   = (ITER - FIRST < GRP) ? (ITER - FIRST) : GRP;
    cfb_cordic_group #(.IW(IW), .AW(AW), .FIRST(FIRST), .CNT(CNT)) u_grp (
      .clk(clk), .rst(rst),
      .v_in(gv[g]), .x_in(gx[g]), .y_in(gy[g]), .z_in(gz[g]),
      .v_out(gv[g+1]), .x_out(gx[g+1]), .y_out(gy[g+1]), .z_out(gz[g+1])
    );
  end

  cfb_align #(.W(2 * DW), .DEPTH(ALN)) u_align (
    .clk(clk), .rst(rst), .d({in_i, in_q}), .q(fwd_d)
  );

  cfb_sub_sat #(.DW(DW), .GUARD(GUARD), .IW(IW)) u_sub (
    .clk(clk), .rst(rst), .v_in(gv[NGRP]),
    .rx(gx[NGRP]), .ry(gy[NGRP]),
    .ii(fwd_d[2*DW-1:DW]), .iq(fwd_d[DW-1:0]),
    .v_out(out_valid), .out_i(out_i), .out_q(out_q)
  );

  AST_RESIDUE_SMALL: assert property (@(posedge clk) disable iff (rst)
    gv[NGRP] |-> (((gz[NGRP] < 0) ? -gz[NGRP] : gz[NGRP])
                  <= AW'(atan_scaled(ITER - 1, AW) + 16))); // R5

endmodule

// File: tb/tb_cfb_return_path.sv
`timescale 1ns/1ps
module tb_cfb_return_path;
  localparam int DW  = 12;
  localparam int AW  = 16;
  localparam int LAT = 5;
  localparam int TOL = 10;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_valid = 1'b0, in_valid = 1'b0, ang_valid = 1'b0;
  logic signed [DW-1:0] fb_i = '0, fb_q = '0, in_i = '0, in_q = '0;
  logic signed [AW-1:0] ang = '0;
  logic out_valid;
  logic signed [DW-1:0] out_i, out_q;

  always #10 clk = ~clk;

  cfb_return_path dut (
    .clk(clk), .rst(rst),
    .fb_valid(fb_valid), .fb_i(fb_i), .fb_q(fb_q),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .ang_valid(ang_valid), .ang(ang),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0, fails = 0, cyc = 0, seed = 7;
  bit done = 0;
  int last_i = 0, last_q = 0;
  bit    exp_v [0:HMAX-1];
  int    exp_i [0:HMAX-1];
  int    exp_q [0:HMAX-1];
  string exp_t [0:HMAX-1];

  function automatic int clamp(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic lcg(output int r, input int span);
    seed = seed * 1103515245 + 12345;
    r = ((seed >>> 8) & 32'h7fffff) % (2 * span + 1) - span;
  endtask

  task automatic check_out(input int j);
    string t;
    t = exp_t[j];
    checks++;
    if (out_valid !== exp_v[j]) begin
      fails++;
      $display("FAIL %s out_valid actual %0b expected %0b (cycle %0d)",
               (t == "R1") ? "R1" : "R2", out_valid, exp_v[j], cyc);
    end
    if (exp_v[j]) begin
      checks++;
      if (absd(int'(out_i), exp_i[j]) > TOL || absd(int'(out_q), exp_q[j]) > TOL) begin
        fails++;
        $display("FAIL %s result actual (%0d,%0d) expected (%0d,%0d)",
                 t, out_i, out_q, exp_i[j], exp_q[j]);
      end
      last_i = int'(out_i);
      last_q = int'(out_q);
    end else begin
      checks++;
      if (int'(out_i) != last_i || int'(out_q) != last_q) begin
        fails++;
        $display("FAIL %s idle outputs actual (%0d,%0d) expected (%0d,%0d)",
                 (t == "R1") ? "R1" : "R10", out_i, out_q, last_i, last_q);
      end
    end
  endtask

  // One clock: drive at negedge, model, wait, sample at the next negedge.
  task automatic step(input bit fv, input bit iv, input bit av,
                      input int fi, input int fq, input int xi, input int xq,
                      input int a, input string tag);
    int j;
    real th, ri, rq;
    fb_valid = fv; in_valid = iv; ang_valid = av;
    fb_i = DW'(fi); fb_q = DW'(fq); in_i = DW'(xi); in_q = DW'(xq); ang = AW'(a);
    j = cyc % HMAX;
    exp_v[j] = fv && iv && av && !rst;
    exp_t[j] = tag;
    th = real'(a) * 3.14159265358979 / 32768.0;
    ri = $cos(th) * fi - $sin(th) * fq;
    rq = $sin(th) * fi + $cos(th) * fq;
    exp_i[j] = clamp(int'(real'(xi) - ri));
    exp_q[j] = clamp(int'(real'(xq) - rq));
    @(posedge clk);
    @(negedge clk);
    if (cyc >= LAT - 1) check_out((cyc - (LAT - 1)) % HMAX);
    else begin
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R8 out_valid during start actual %0b expected 0", out_valid);
      end
    end
    cyc++;
  endtask

  task automatic fire(input int fi, input int fq, input int xi, input int xq,
                      input int a, input string tag);
    step(1, 1, 1, fi, fq, xi, xq, a, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      int g1, g2;
      lcg(g1, 2000);
      lcg(g2, 2000);
      step(0, 0, 0, g1, g2, g2, g1, g1 * 9, "R10");
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    rst = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
      fails++;
      $display("FAIL R8 reset state actual (%0b,%0d,%0d) expected (0,0,0)",
               out_valid, out_i, out_q);
    end

    // R6: zero angle, gain must be unity
    fire(300, -200, 100, 50, 0, "R6");
    fire(-1000, 700, 0, 0, 0, "R6");
    fire(1024, 1024, -500, 500, 0, "R6");
    idle(6);

    // R3/R4: angles inside the direct range, counterclockwise positive
    fire(800, -300, 200, -100, 5461, "R4");
    fire(-600, 900, -50, 400, -8192, "R3");
    fire(1000, 0, 0, 0, 14564, "R4");
    fire(0, 1000, 300, 300, -14564, "R3");
    idle(6);

    // R5: angles beyond +/-pi/2, the edges and -pi
    fire(700, 400, 0, 0, 21845, "R5");
    fire(-500, 900, 100, -100, -27307, "R5");
    fire(1000, -250, 0, 0, -32768, "R5");
    fire(600, 600, -200, 0, 32585, "R5");
    fire(900, -900, 0, 50, 16384, "R5");
    fire(-900, 300, 0, 0, -16385, "R5");
    idle(6);

    // R1: two strobes of three never produce a result
    step(1, 1, 0, 900, 900, 1500, -1500, 0, "R1");
    step(1, 0, 1, -900, 900, 1500, 1500, 0, "R1");
    step(0, 1, 1, 900, -900, -1500, 1500, 0, "R1");
    step(1, 0, 0, 400, 400, 400, 400, 0, "R1");
    idle(5);

    // R7: opposite-signed large operands clip
    fire(-1024, 1024, 2047, -2048, 0, "R7");
    fire(1024, -1024, -2048, 2047, 0, "R7");
    fire(1024, 1024, -2000, -2000, 8192, "R7");
    idle(5);

    // R9: one sample per cycle, every pairing distinct
    for (int k = 0; k < 40; k++) begin
      int a1, a2, a3, a4, a5;
      lcg(a1, 1024); lcg(a2, 1024); lcg(a3, 1000); lcg(a4, 1000); lcg(a5, 32767);
      fire(a1, a2, a3, a4, a5, "R9");
    end
    idle(LAT + 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule